// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block receives frames one byte per cycle and places each frame into a host buffer. A ring of receive descriptors describes those buffers, and the descriptors are held in an internal memory. The host fills in a descriptor with a 24-bit buffer address and a negated 16-bit buffer size. It then hands the descriptor to the device by setting the ownership bit.

When the first byte of a frame arrives, the block looks at the descriptor under its ring index. If the device owns that descriptor, every byte is passed out on a buffer write port, up to the buffer size. At the end of the frame the block writes back the message length (CRC bytes included) and a status byte. The write-back also clears ownership, and the block then pulses a receive event and advances the index. If the host still owns the descriptor, the frame is dropped whole and a missed-frame pulse is raised instead.

The ring length is two to the power of a 3-bit code, limited by the largest ring the memory holds. Buffer storage and CRC checking are outside the block. CRC and framing error flags arrive together with the last byte.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset every descriptor word reads as zero, which means every entry is host-owned. In the same state `rx_event`, `missed_frame` and `buf_we` are low, and the ring index is 0.
- R2: Host access: `host_addr` is {entry, word}, with the word select in bit 0. A write lands at the clock edge. A read returns `host_rdata` one cycle after `host_addr` is presented.
- R3: Descriptor layout: word 0 holds the ownership flag in bit 31, the status byte in bits 31:24 and the buffer address in bits 23:0. Word 1 holds the two's-complement negated buffer size in bits 15:0 and the message length in bits 27:16. In a frame claimed on a device-owned descriptor, the byte at index k raises `buf_we` in the same cycle, with `buf_addr` = address + k and `buf_wdata` = the byte.
- R4: At the end of a claimed frame, the status byte is written with bit 31 clear and bits 1:0 set (a good frame reads 0x03). The message length is written as the number of bytes received. The buffer address and the size field are left unchanged.
- R5: `rx_event` is a one-cycle pulse in the cycle after the last byte of each claimed frame.
- R6: Bytes beyond the buffer size are not written. They set the overflow flag 0x10, and the stored length becomes the buffer size.
- R7: `in_crc_err` and `in_frame_err`, sampled with the last byte, set status flags 0x08 and 0x20.
- R8: Status bit 0x40 is set whenever any of the overflow, CRC or framing flags is set.
- R9: A frame whose first byte finds the current descriptor host-owned makes no buffer write and changes no descriptor. It pulses `missed_frame` in the cycle after its last byte and does not advance the ring index.
- R10: The ring index advances by one per claimed frame, modulo 2^min(`ring_len_code`, MAX_LOG). A code of 0 keeps every frame in entry 0.
- R11: A host write that grants ownership in the same cycle as a frame's first byte does not affect that frame, which is missed. The following frame claims the entry.
- R12: A one-byte frame, whose first and last byte coincide, is claimed, written and returned with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_len_code | input | 3 | Ring length exponent |
| host_we | input | 1 | Host descriptor write strobe |
| host_addr | input | MAX_LOG+1 | Host {entry, word} address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle latency |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_err | input | 1 | CRC error, valid with last byte |
| in_frame_err | input | 1 | Framing error, valid with last byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 24 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| rx_event | output | 1 | Descriptor returned to host |
| missed_frame | output | 1 | Frame dropped, no owned descriptor |

## Verification
The host's ownership grant and the device's ownership decision can fall in the same cycle. The bench provokes this by writing the ownership bit of the current entry on the very clock edge that carries a frame's first byte. It judges the result at the ports:
- no `buf_we` appears during that frame;
- `missed_frame` pulses after its last byte;
- the descriptor reads back as host-granted and unchanged by the device;
- the next frame is claimed by that same entry.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned BADDR_W = 24;
   localparam int unsigned SIZE_W  = 16;
   localparam int unsigned LEN_W   = 12;
   localparam int unsigned OWN_BIT = 31;

   typedef enum logic [1:0] {
      FM_IDLE = 2'd0,
      FM_FILL = 2'd1,
      FM_DROP = 2'd2
   } fill_mode_e;

   typedef struct packed {
      logic fram;
      logic ovf;
      logic crc;
   } rx_err_t;

   // Status byte written back into bits 31:24 of word 0; ownership bit ends up clear.
   function automatic logic [7:0] make_status(rx_err_t e);
      logic [7:0] s;
      s = 8'h03;
      if (e.fram) s = s | 8'h20;
      if (e.ovf)  s = s | 8'h10;
      if (e.crc)  s = s | 8'h08;
      if (e.fram || e.ovf || e.crc) s = s | 8'h40;
      return s;
   endfunction
endpackage

// File: rtl/rxr_desc_mem.sv
`timescale 1ns/1ps
module rxr_desc_mem
   import rxr_pkg::*;
#(
   parameter int unsigned MAX_LOG     = 4,
   parameter bit          REG_HOST_RD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_we,
   input  logic [MAX_LOG:0]         host_addr,
   input  logic [WORD_W-1:0]        host_wdata,
   output logic [WORD_W-1:0]        host_rdata,
   input  logic [MAX_LOG-1:0]       dev_rd_ent,
   output logic [WORD_W-1:0]        dev_rd_w0,
   output logic [WORD_W-1:0]        dev_rd_w1,
   input  logic                     dev_wb_en,
   input  logic [MAX_LOG-1:0]       dev_wb_ent,
   input  logic [7:0]               dev_wb_status,
   input  logic [LEN_W-1:0]         dev_wb_len
);
   localparam int unsigned ENTRIES = 1 << MAX_LOG;

   logic [WORD_W-1:0] w0_q [ENTRIES];
   logic [WORD_W-1:0] w1_q [ENTRIES];
   logic [MAX_LOG-1:0] host_ent;
   logic [WORD_W-1:0]  host_sel;

   assign host_ent = host_addr[MAX_LOG:1];

   // Device write-back is placed after the host write so its fields win on a collision.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            w0_q[i] <= '0;
            w1_q[i] <= '0;
         end
      end else begin
         if (host_we) begin
            if (host_addr[0]) w1_q[host_ent] <= host_wdata;
            else              w0_q[host_ent] <= host_wdata;
         end
         if (dev_wb_en) begin
            w0_q[dev_wb_ent][31:24] <= dev_wb_status;
            w1_q[dev_wb_ent][27:16] <= dev_wb_len;
         end
      end
   end

   assign dev_rd_w0 = w0_q[dev_rd_ent];
   assign dev_rd_w1 = w1_q[dev_rd_ent];
   assign host_sel  = host_addr[0] ? w1_q[host_ent] : w0_q[host_ent];

   generate
      if (REG_HOST_RD) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) host_rdata <= '0;
            else        host_rdata <= host_sel;
         end
      end else begin : g_rd_comb
         assign host_rdata = host_sel;
      end
   endgenerate
endmodule

// File: rtl/rxr_fill.sv
`timescale 1ns/1ps
module rxr_fill
   import rxr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   input  logic               in_last,
   input  logic               in_crc_err,
   input  logic               in_frame_err,
   input  logic               claim_ok,
   input  logic [BADDR_W-1:0] desc_base,
   input  logic [SIZE_W-1:0]  desc_size,
   output logic               first_o,
   output logic               buf_we,
   output logic [BADDR_W-1:0] buf_addr,
   output logic [7:0]         buf_wdata,
   output logic               done_o,
   output logic               done_fill_o,
   output logic [LEN_W-1:0]   done_len,
   output rx_err_t            done_err
);
   fill_mode_e         mode_q;
   logic [BADDR_W-1:0] base_q;
   logic [SIZE_W-1:0]  size_q;
   logic [SIZE_W-1:0]  cnt_q;
   logic               ovf_q;

   logic               cur_fill;
   logic [BADDR_W-1:0] cur_base;
   logic [SIZE_W-1:0]  cur_size;
   logic [SIZE_W-1:0]  idx_b;
   logic [SIZE_W-1:0]  nxt_cnt;
   logic               in_buf;
   logic               ovf_now;
   logic [SIZE_W-1:0]  len_full;
   logic               unused_len_hi;

   assign first_o  = in_valid && (mode_q == FM_IDLE);
   assign cur_fill = first_o ? claim_ok : (mode_q == FM_FILL);
   assign cur_base = first_o ? desc_base : base_q;
   assign cur_size = first_o ? desc_size : size_q;
   assign idx_b    = first_o ? '0 : cnt_q;
   assign nxt_cnt  = idx_b + SIZE_W'(1);
   assign in_buf   = idx_b < cur_size;

   assign buf_we    = in_valid && cur_fill && in_buf;
   assign buf_addr  = cur_base + BADDR_W'(idx_b);
   assign buf_wdata = in_data;

   assign ovf_now  = (!first_o && ovf_q) || (in_valid && cur_fill && !in_buf);
   // Length saturates at the buffer size once a byte has fallen outside it.
   assign len_full = in_buf ? nxt_cnt : cur_size;

   assign done_o        = in_valid && in_last;
   assign done_fill_o   = cur_fill;
   assign done_len      = len_full[LEN_W-1:0];
   assign unused_len_hi = ^len_full[SIZE_W-1:LEN_W];
   assign done_err.fram = in_frame_err;
   assign done_err.ovf  = ovf_now;
   assign done_err.crc  = in_crc_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= FM_IDLE;
         base_q <= '0;
         size_q <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
      end else if (in_valid) begin
         if (in_last)       mode_q <= FM_IDLE;
         else if (cur_fill) mode_q <= FM_FILL;
         else               mode_q <= FM_DROP;
         base_q <= cur_base;
         size_q <= cur_size;
         cnt_q  <= (&idx_b) ? idx_b : nxt_cnt;
         ovf_q  <= ovf_now;
      end
   end
endmodule

// File: rtl/rxr_ring_writer.sv
`timescale 1ns/1ps
module rxr_ring_writer
   import rxr_pkg::*;
#(
   parameter int unsigned MAX_LOG     = 4,
   parameter bit          REG_HOST_RD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          ring_len_code,
   input  logic                host_we,
   input  logic [MAX_LOG:0]    host_addr,
   input  logic [31:0]         host_wdata,
   output logic [31:0]         host_rdata,
   input  logic                in_valid,
   input  logic [7:0]          in_data,
   input  logic                in_last,
   input  logic                in_crc_err,
   input  logic                in_frame_err,
   output logic                buf_we,
   output logic [23:0]         buf_addr,
   output logic [7:0]          buf_wdata,
   output logic                rx_event,
   output logic                missed_frame
);
   generate
      if (MAX_LOG < 1 || MAX_LOG > 7) begin : g_bad_log
         $error("MAX_LOG must lie in 1..7");
      end
   endgenerate

   logic [MAX_LOG-1:0] idx_q;
   logic [MAX_LOG-1:0] ent_q;
   logic [MAX_LOG-1:0] ring_mask;
   logic [MAX_LOG-1:0] cur_ent;
   logic [MAX_LOG-1:0] wb_ent;
   logic [2:0]         log_eff;
   logic [WORD_W-1:0]  rd_w0;
   logic [WORD_W-1:0]  rd_w1;
   logic [SIZE_W-1:0]  desc_size;
   logic               unused_desc_bits;
   logic               first_b;
   logic               done_b;
   logic               done_fill;
   logic [LEN_W-1:0]   done_len;
   rx_err_t            done_err;
   logic               wb_en;
   logic               rx_event_q;
   logic               missed_q;

   assign log_eff = (ring_len_code > 3'(MAX_LOG)) ? 3'(MAX_LOG) : ring_len_code;

   always_comb begin
      for (int b = 0; b < MAX_LOG; b++) ring_mask[b] = (b < int'(log_eff));
   end

   assign cur_ent   = idx_q & ring_mask;
   assign desc_size = ~rd_w1[SIZE_W-1:0] + SIZE_W'(1);
   assign unused_desc_bits = ^{rd_w0[30:24], rd_w1[31:16]};
   assign wb_ent    = first_b ? cur_ent : ent_q;
   assign wb_en     = done_b && done_fill;

   rxr_desc_mem #(.MAX_LOG(MAX_LOG), .REG_HOST_RD(REG_HOST_RD)) u_mem (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_we      (host_we),
      .host_addr    (host_addr),
      .host_wdata   (host_wdata),
      .host_rdata   (host_rdata),
      .dev_rd_ent   (cur_ent),
      .dev_rd_w0    (rd_w0),
      .dev_rd_w1    (rd_w1),
      .dev_wb_en    (wb_en),
      .dev_wb_ent   (wb_ent),
      .dev_wb_status(make_status(done_err)),
      .dev_wb_len   (done_len)
   );

   rxr_fill u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_last     (in_last),
      .in_crc_err  (in_crc_err),
      .in_frame_err(in_frame_err),
      .claim_ok    (rd_w0[OWN_BIT]),
      .desc_base   (rd_w0[BADDR_W-1:0]),
      .desc_size   (desc_size),
      .first_o     (first_b),
      .buf_we      (buf_we),
      .buf_addr    (buf_addr),
      .buf_wdata   (buf_wdata),
      .done_o      (done_b),
      .done_fill_o (done_fill),
      .done_len    (done_len),
      .done_err    (done_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         ent_q      <= '0;
         rx_event_q <= 1'b0;
         missed_q   <= 1'b0;
      end else begin
         if (first_b) ent_q <= cur_ent;
         if (wb_en)   idx_q <= (wb_ent + MAX_LOG'(1)) & ring_mask;
         rx_event_q <= wb_en;
         missed_q   <= done_b && !done_fill;
      end
   end

   assign rx_event     = rx_event_q;
   assign missed_frame = missed_q;
endmodule

// File: rtl/rxr_ring_writer_chk.sv
`timescale 1ns/1ps
module rxr_ring_writer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_last,
   input logic        buf_we,
   input logic [23:0] buf_addr,
   input logic        rx_event,
   input logic        missed_frame
);
   AST_EVENT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> $past(in_valid && in_last)); // R5

   AST_MISS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      missed_frame |-> $past(in_valid && in_last)); // R9

   AST_EVENT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_event && missed_frame)); // R9

   AST_WRITE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> in_valid); // R3

   AST_WRITE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && $past(buf_we) && !$past(in_last)) |-> (buf_addr == $past(buf_addr) + 24'd1)); // R3
endmodule

bind rxr_ring_writer rxr_ring_writer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_last     (in_last),
   .buf_we      (buf_we),
   .buf_addr    (buf_addr),
   .rx_event    (rx_event),
   .missed_frame(missed_frame)
);

// File: tb/tb_rxr_ring_writer.sv
`timescale 1ns/1ps
module tb_rxr_ring_writer;
   localparam int MAX_LOG = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        ring_len_code = 3'd2;
   logic              host_we = 1'b0;
   logic [MAX_LOG:0]  host_addr = '0;
   logic [31:0]       host_wdata = '0;
   logic [31:0]       host_rdata;
   logic              in_valid = 1'b0;
   logic [7:0]        in_data = '0;
   logic              in_last = 1'b0;
   logic              in_crc_err = 1'b0;
   logic              in_frame_err = 1'b0;
   logic              buf_we;
   logic [23:0]       buf_addr;
   logic [7:0]        buf_wdata;
   logic              rx_event;
   logic              missed_frame;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   rxr_ring_writer #(.MAX_LOG(MAX_LOG)) dut (
      .clk(clk), .rst_n(rst_n), .ring_len_code(ring_len_code),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .in_crc_err(in_crc_err), .in_frame_err(in_frame_err),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .rx_event(rx_event), .missed_frame(missed_frame)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status(input bit ovf, input bit crc, input bit fram);
      logic [7:0] s;
      s = 8'h03;
      if (fram) s = s | 8'h20;
      if (ovf)  s = s | 8'h10;
      if (crc)  s = s | 8'h08;
      if (ovf || crc || fram) s = s | 8'h40;
      return s;
   endfunction

   task automatic host_wr(input int ent, input bit sel, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = {4'(ent), sel}; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_rd(input int ent, input bit sel, output logic [31:0] d);
      @(negedge clk);
      host_addr = {4'(ent), sel};
      @(negedge clk);
      #1 d = host_rdata;
   endtask

   task automatic set_desc(input int ent, input logic [23:0] base, input int size);
      host_wr(ent, 1'b1, {16'h0000, 16'(-size)});
      host_wr(ent, 1'b0, {8'h80, base});
   endtask

   task automatic check_desc(input string req, input int ent, input logic [7:0] st,
                             input logic [23:0] base, input int len, input int size);
      logic [31:0] d;
      host_rd(ent, 1'b0, d);
      chk(req, "desc word0", d, {st, base});
      host_rd(ent, 1'b1, d);
      chk(req, "desc word1", d, {4'h0, 12'(len), 16'(-size)});
   endtask

   task automatic send_frame(input int n, input int size, input logic [23:0] base,
                             input bit own, input bit crc, input bit fram, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = 8'(k * 7 + 3); in_last = (k == n - 1);
         in_crc_err = crc && (k == n - 1); in_frame_err = fram && (k == n - 1);
         #1;
         chk(req, "buf_we", 32'(buf_we), 32'(own && (k < size)));
         if (own && (k < size)) begin
            chk(req, "buf_addr", 32'(buf_addr), 32'(base + 24'(k)));
            chk(req, "buf_wdata", 32'(buf_wdata), 32'(8'(k * 7 + 3)));
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; in_frame_err = 1'b0;
      #1;
      chk(req, "rx_event", 32'(rx_event), 32'(own));
      chk(req, "missed_frame", 32'(missed_frame), 32'(!own));
      @(negedge clk);
      #1;
      chk("R5", "event pulse width", 32'({rx_event, missed_frame}), 32'(0));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1", "rx_event", 32'(rx_event), 0);
      chk("R1", "missed_frame", 32'(missed_frame), 0);
      chk("R1", "buf_we", 32'(buf_we), 0);
      host_rd(0, 1'b0, d); chk("R1", "entry0 word0", d, 0);
      host_rd(5, 1'b1, d); chk("R1", "entry5 word1", d, 0);
   endtask

   task automatic t_host_rw();
      logic [31:0] d;
      host_wr(9, 1'b1, 32'hA5A5_1234);
      host_rd(9, 1'b1, d); chk("R2", "host readback", d, 32'hA5A5_1234);
      host_rd(9, 1'b0, d); chk("R2", "other word untouched", d, 0);
   endtask

   task automatic t_good();
      set_desc(0, 24'h001000, 64);
      send_frame(10, 64, 24'h001000, 1'b1, 1'b0, 1'b0, "R3");
      check_desc("R4", 0, 8'h03, 24'h001000, 10, 64);
   endtask

   task automatic t_overflow();
      set_desc(1, 24'h002000, 8);
      send_frame(12, 8, 24'h002000, 1'b1, 1'b0, 1'b0, "R6");
      check_desc("R6", 1, exp_status(1'b1, 1'b0, 1'b0), 24'h002000, 8, 8);
   endtask

   task automatic t_flags();
      set_desc(2, 24'h003000, 64);
      send_frame(6, 64, 24'h003000, 1'b1, 1'b1, 1'b0, "R7");
      check_desc("R8", 2, exp_status(1'b0, 1'b1, 1'b0), 24'h003000, 6, 64);
      set_desc(3, 24'h004000, 64);
      send_frame(5, 64, 24'h004000, 1'b1, 1'b0, 1'b1, "R7");
      check_desc("R8", 3, exp_status(1'b0, 1'b0, 1'b1), 24'h004000, 5, 64);
   endtask

   task automatic t_missed_wrap();
      // Ring of 4: index wrapped to entry 0, which the host has not re-armed.
      send_frame(7, 64, 24'h001000, 1'b0, 1'b0, 1'b0, "R9");
      check_desc("R9", 0, 8'h03, 24'h001000, 10, 64);
      set_desc(0, 24'h005000, 64);
      send_frame(1, 64, 24'h005000, 1'b1, 1'b0, 1'b0, "R12");
      check_desc("R10", 0, 8'h03, 24'h005000, 1, 64);
   endtask

   task automatic t_grant_collision();
      host_wr(1, 1'b1, {16'h0000, 16'(-64)});
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (k == 0) begin
            host_we = 1'b1; host_addr = {4'd1, 1'b0}; host_wdata = {8'h80, 24'h008000};
         end else begin
            host_we = 1'b0;
         end
         in_valid = 1'b1; in_data = 8'(k); in_last = (k == 2);
         #1 chk("R11", "buf_we on racing frame", 32'(buf_we), 0);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      #1;
      chk("R11", "missed_frame", 32'(missed_frame), 1);
      chk("R11", "rx_event", 32'(rx_event), 0);
      begin
         logic [31:0] d;
         host_rd(1, 1'b0, d); chk("R11", "granted word0", d, {8'h80, 24'h008000});
      end
      send_frame(4, 64, 24'h008000, 1'b1, 1'b0, 1'b0, "R11");
      check_desc("R11", 1, 8'h03, 24'h008000, 4, 64);
   endtask

   task automatic t_single_entry_ring();
      logic [31:0] d;
      ring_len_code = 3'd0;
      set_desc(0, 24'h006000, 32);
      send_frame(3, 32, 24'h006000, 1'b1, 1'b0, 1'b0, "R10");
      check_desc("R10", 0, 8'h03, 24'h006000, 3, 32);
      set_desc(0, 24'h007000, 32);
      send_frame(2, 32, 24'h007000, 1'b1, 1'b0, 1'b0, "R10");
      check_desc("R10", 0, 8'h03, 24'h007000, 2, 32);
      host_rd(2, 1'b0, d);
      chk("R10", "entry2 untouched", d, {exp_status(1'b0, 1'b1, 1'b0), 24'h003000});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_host_rw();
      t_good();
      t_overflow();
      t_flags();
      t_missed_wrap();
      t_grant_collision();
      t_single_entry_ring();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule